// File: doc/BRIEF.md
# Quadrature Quarter-Rate Bitstream Mixer

This block sits directly behind a one-bit bandpass delta-sigma modulator whose passband is centred at one quarter of its sampling rate. It shifts that passband to baseband by mixing the bitstream with a quarter-rate cosine and sine. It produces an in-phase and a quadrature ternary stream, each carrying +1, 0 or -1 per sample. Two decimation filters downstream consume these streams.

At a quarter of the sample rate, each carrier sample is +1, 0 or -1. The product of the carrier with a one-bit input therefore needs no multiplier or table. The block passes, negates or zeroes the input according to a two-bit phase counter that moves one step per accepted sample. The quadrature lane uses the same counter, offset by one step.

The input side is a plain strobe (`smp_en`), and the output side carries a valid flag. There is no ready signal, so the block cannot apply back-pressure and the consumer cannot stall it. The consumer must take every sample in the cycle in which `mix_valid` is high. The modulator must present `mod_bit` in every cycle that `smp_en` is high.

Top module: `quad_bitstream_mixer`

## Requirements
- R1: While `rst` is high at a clock edge, the block clears `mix_i`, `mix_q` and `mix_valid` to 0 and returns the phase index to 0. The first enabled sample after reset uses phase 0.
- R2: `mod_bit`=1 stands for +1 and `mod_bit`=0 stands for -1. Outputs are two's complement at width OUT_W, with +1 = 0...01, 0 = 0...00 and -1 = 1...11. On a sample taken at phase 0, `mix_i` equals the input value. At phase 2, `mix_i` equals the negated input value.
- R3: On a sample taken at phase 1 or phase 3, `mix_i` is 0 whatever `mod_bit` is.
- R4: At phase 1, `mix_q` equals the input value. At phase 3, `mix_q` equals the negated input value. At phases 0 and 2, `mix_q` is 0 whatever `mod_bit` is.
- R5: The phase index steps by one, modulo 4, only at edges where `smp_en` is high. Any run of cycles with `smp_en` low leaves the phase unchanged, so the next sample resumes the sequence where it stopped.
- R6: Outputs appear one clock after the sample edge. `mix_valid` is high exactly in the cycle after an edge at which `smp_en` was high.
- R7: In a cycle that follows an edge where `smp_en` was low, `mix_i` and `mix_q` keep their previous values.
- R8: While `mix_valid` is high, exactly one of `mix_i` and `mix_q` is nonzero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oversampling clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_en | input | 1 | Sample strobe; `mod_bit` is taken when high |
| mod_bit | input | 1 | Modulator output bit (1 = +1, 0 = -1) |
| mix_i | output | OUT_W | In-phase product (input times cosine), two's complement |
| mix_q | output | OUT_W | Quadrature product (input times sine), two's complement |
| mix_valid | output | 1 | High for one cycle when new products are present |

## Verification
The bench builds the block with OUT_W = 2, the default. At that width every output code is one of 01, 00 or 11, so a stray negation or a dropped zero changes the value the bench observes.

The strobe pattern mixes long enabled runs with random gaps. This exercises all four phases against both input polarities, and resumption after a stall from every phase. A reset in the middle of the run confirms that the cosine lane restarts at phase 0.

// File: rtl/bsmix_pkg.sv
package bsmix_pkg;
  localparam int PHASE_W = 2;
  localparam int PHASE_N = 1 << PHASE_W;
  typedef logic [PHASE_W-1:0] phase_t;
  typedef enum logic [1:0] {
    CAR_ZERO = 2'd0,
    CAR_POS  = 2'd1,
    CAR_NEG  = 2'd2
  } carrier_e;
endpackage

// File: rtl/bsmix_phase.sv
module bsmix_phase
  import bsmix_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   step,
  output phase_t phase
);
  always_ff @(posedge clk) begin
    if (rst) phase <= '0;
    else if (step) phase <= phase + 1'b1;
  end

  AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(phase)); // R5
  AST_PHASE_STEP: assert property (@(posedge clk) disable iff (rst)
    step |=> (phase == phase_t'($past(phase) + 1'b1))); // R5
endmodule

// File: rtl/bsmix_lane.sv
module bsmix_lane
  import bsmix_pkg::*;
#(
  parameter int OUT_W = 2,
  parameter int LAG   = 0
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en,
  input  logic                    bit_in,
  input  phase_t                  phase,
  output logic signed [OUT_W-1:0] y
);
  localparam logic signed [OUT_W-1:0] V_POS = OUT_W'(1);
  localparam logic signed [OUT_W-1:0] V_NEG = '1;

  phase_t                  rel;
  carrier_e                car;
  logic signed [OUT_W-1:0] sval;
  logic signed [OUT_W-1:0] prod;

  always_comb begin
    rel  = phase - phase_t'(LAG);
    car  = (rel == phase_t'(0)) ? CAR_POS :
           (rel == phase_t'(2)) ? CAR_NEG : CAR_ZERO;
    sval = bit_in ? V_POS : V_NEG;
    case (car)
      CAR_POS: prod = sval;
      CAR_NEG: prod = -sval;
      default: prod = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) y <= '0;
    else if (en) y <= prod;
  end

  AST_LANE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(y)); // R7
  AST_LANE_TERNARY: assert property (@(posedge clk) disable iff (rst)
    en |=> (y == V_POS || y == '0 || y == V_NEG)); // R2
endmodule

// File: rtl/quad_bitstream_mixer.sv
module quad_bitstream_mixer
  import bsmix_pkg::*;
#(
  parameter int OUT_W = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    smp_en,
  input  logic                    mod_bit,
  output logic signed [OUT_W-1:0] mix_i,
  output logic signed [OUT_W-1:0] mix_q,
  output logic                    mix_valid
);
  localparam int LANES = 2;

  phase_t                  phase;
  logic signed [OUT_W-1:0] lane_y [LANES];

  bsmix_phase u_phase (
    .clk   (clk),
    .rst   (rst),
    .step  (smp_en),
    .phase (phase)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    bsmix_lane #(.OUT_W(OUT_W), .LAG(g)) u_lane (
      .clk    (clk),
      .rst    (rst),
      .en     (smp_en),
      .bit_in (mod_bit),
      .phase  (phase),
      .y      (lane_y[g])
    );
  end

  assign mix_i = lane_y[0];
  assign mix_q = lane_y[1];

  always_ff @(posedge clk) begin
    if (rst) mix_valid <= 1'b0;
    else mix_valid <= smp_en;
  end

  AST_VALID_RISE: assert property (@(posedge clk) disable iff (rst)
    smp_en |=> mix_valid); // R6
  AST_VALID_IDLE: assert property (@(posedge clk) disable iff (rst)
    !smp_en |=> !mix_valid); // R6
  AST_QUAD_EXCL: assert property (@(posedge clk) disable iff (rst)
    mix_valid |-> ((mix_i != '0) != (mix_q != '0))); // R8
endmodule

// File: tb/sim_quad_bitstream_mixer.sv
module sim_quad_bitstream_mixer;
  localparam int W = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0;
  logic bitin = 1'b0;
  logic signed [W-1:0] mi, mq;
  logic mv;

  int n_chk = 0;
  int n_bad = 0;
  int ph = 0;
  int last_i = 0;
  int last_q = 0;
  bit stalled = 0;

  always #2 clk = ~clk;

  quad_bitstream_mixer #(.OUT_W(W)) u0 (
    .clk(clk), .rst(rst), .smp_en(en), .mod_bit(bitin),
    .mix_i(mi), .mix_q(mq), .mix_valid(mv)
  );

  function automatic int mixv(int p, int lag, logic b);
    int r = (p - lag + 4) % 4;
    int s = b ? 1 : -1;
    if (r == 0) return s;
    if (r == 2) return -s;
    return 0;
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic drive(logic e, logic b);
    int ei, eq;
    en = e;
    bitin = b;
    @(negedge clk);
    if (e) begin
      ei = mixv(ph, 0, b);
      eq = mixv(ph, 1, b);
      chk((ph % 2 == 0) ? "R2" : "R3", int'(mi), ei);
      chk("R4", int'(mq), eq);
      chk("R6", int'(mv), 1);
      chk("R8", int'(mi != 0) + int'(mq != 0), 1);
      if (stalled) begin
        chk("R5", int'(mi), ei);
        chk("R5", int'(mq), eq);
      end
      last_i = ei;
      last_q = eq;
      ph = (ph + 1) % 4;
      stalled = 0;
    end else begin
      chk("R7", int'(mi), last_i);
      chk("R7", int'(mq), last_q);
      chk("R6", int'(mv), 0);
      stalled = 1;
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    en = 1'b1;
    bitin = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", int'(mi), 0);
    chk("R1", int'(mq), 0);
    chk("R1", int'(mv), 0);
    rst = 1'b0;
    ph = 0;
    last_i = 0;
    last_q = 0;
    stalled = 0;
  endtask

  initial begin
    #(4 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    @(negedge clk);
    do_reset();
    for (int k = 0; k < 8; k++) drive(1'b1, 1'b1);
    for (int k = 0; k < 8; k++) drive(1'b1, 1'b0);
    for (int k = 0; k < 8; k++) drive(1'b1, k[0]);
    for (int s = 0; s < 4; s++) begin
      for (int k = 0; k < 5; k++) drive(1'b0, k[0]);
      drive(1'b1, s[0]);
    end
    for (int k = 0; k < 3000; k++) drive(($urandom % 3) != 0, $urandom % 2);
    drive(1'b1, 1'b1);
    do_reset();
    drive(1'b1, 1'b0);
    for (int k = 0; k < 2000; k++) drive(($urandom % 4) == 0, $urandom % 2);
    en = 1'b0;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule